// File: doc/BRIEF.md
# Microcoded Instruction Step Sequencer

This block is the control unit for a small accumulator processor. After a start pulse it runs a four-step fetch sequence. It then reads the opcode from the operation register and hands execution to one of five step chains. The chains have 2, 2, 6, 8 and 10 steps. Several opcodes can share one chain. On each step the running chain raises exactly one named activation strobe, or none on an idle step. The datapath uses these strobes to move and clock its registers. Once the chain has finished, control goes back to fetch, and the loop runs until reset.

The selector and every chain talk over a four-phase request/acknowledge exchange. The request rises, the acknowledge rises once the last step has been issued, the request falls, and then the acknowledge falls. The design uses one clock throughout, and each step lasts one clock. Every handshake costs a fixed four cycles of overhead. The fetch marker comes first, and the first fetch strobe follows it by one cycle. The execute marker comes eight cycles after the fetch marker, and the first execute strobe follows it by one cycle. The next fetch marker comes four cycles after the last step of the chain.

Top module: `stepseq_ctrl`

## Requirements
- R1: While reset is low, and after reset until the first start pulse, all strobes and both markers are 0.
- R2: A start pulse sampled on a clock edge makes fetch_start_o high in the following cycle for one clock. Over the next four cycles the strobe bits are issued in this order: 13 (PC to MAR), 3 (MAR clock), 4 (RAM clock), 14 (operation register clock).
- R3: exec_start_o pulses for one clock exactly 8 cycles after fetch_start_o. The opcode is sampled on the clock edge that ends the cycle before exec_start_o.
- R4: The next fetch_start_o comes N+4 cycles after exec_start_o, where N is the length of the selected chain. Opcodes 8'h01 and 8'h02 use chain 1 and chain 2 (N=2). Opcode 8'h10 uses chain 3 (N=6), 8'h20 uses chain 4 (N=8) and 8'h30 uses chain 5 (N=10).
- R5: Opcode 8'h01 (complement accumulator) issues bit 0 (accumulator complement) and then bit 1 (accumulator clock) on the two cycles after exec_start_o.
- R6: Opcode 8'h20 (load direct) issues bits 2 (GPR to MAR), 3, 4, 5 (memory to GPR), 6 (GPR clock), no strobe on the idle step, then 7 (ALU loads GPR) and 1.
- R7: Opcode 8'h30 (subroutine call) issues bits 2, 3, 8 (PC to GPR), 6, 9 (MAR to PC), 10 (PC clock), 11 (RAM write), 4, 12 (PC increment), 10.
- R8: Opcode 8'h02 (load accumulator from GPR) issues bits 7 and 1. Opcode 8'h10 (store accumulator) issues bits 2, 3, 15 (accumulator to GPR), 6, 11, 4.
- R9: An opcode with no table entry runs chain 1 with no strobe on either step, so the next fetch_start_o follows exec_start_o by 6 cycles.
- R10: No more than one strobe bit is high in any clock.
- R11: Each handshake follows the four-phase order. A request stays high until its acknowledge is seen. A chain raises its acknowledge only while its request is high, and it does not run again until its request has dropped.
- R12: Reset applied in the middle of an instruction stops all strobes and markers at once. After that, nothing happens until a new start pulse arrives.
- R13: A start pulse while the sequencer is running changes neither the timing nor the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the first fetch when idle |
| opcode_i | input | 8 | Opcode from the operation register |
| strobe_o | output | 16 | One-hot activation strobes, bit positions per R2 and R5 to R8 |
| fetch_start_o | output | 1 | One-clock marker at the start of each fetch |
| exec_start_o | output | 1 | One-clock marker when execution is requested |

## Verification
The assertions assume that opcode_i is stable on the edge that ends the cycle before exec_start_o. This is the point at which the operation register has been loaded by fetch. The bench changes the opcode only in the cycle where it sees fetch_start_o, so the value is settled well before that edge. The handshake checks also assume that reset is the only event that can abandon a handshake partway. The bench applies reset mid-run only as a full asynchronous clear, and then restarts the sequencer with a fresh start pulse.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
    localparam int OP_W         = 8;
    localparam int NUM_CHAINS   = 5;
    localparam int CHAIN_SEL_W  = $clog2(NUM_CHAINS);
    localparam int FETCH_STAGES = 4;
    localparam int MAX_STAGES   = 10;
    localparam int IDX_W        = $clog2(MAX_STAGES);
    localparam int NUM_STB      = 16;
    localparam int NO_STB       = -1;

    // strobe bit positions
    localparam int STB_ACC_NOT   = 0;
    localparam int STB_ACC_CLK   = 1;
    localparam int STB_GPR_MAR   = 2;
    localparam int STB_MAR_CLK   = 3;
    localparam int STB_RAM_CLK   = 4;
    localparam int STB_MEM_GPR   = 5;
    localparam int STB_GPR_CLK   = 6;
    localparam int STB_ALU_GPR   = 7;
    localparam int STB_PC_GPR    = 8;
    localparam int STB_MAR_PC    = 9;
    localparam int STB_PC_CLK    = 10;
    localparam int STB_RAM_WR    = 11;
    localparam int STB_PC_INC    = 12;
    localparam int STB_PC_MAR    = 13;
    localparam int STB_OPR_CLK   = 14;
    localparam int STB_ACC_GPR   = 15;

    localparam logic [OP_W-1:0] OP_ACC_NOT  = 8'h01;
    localparam logic [OP_W-1:0] OP_LOAD_GPR = 8'h02;
    localparam logic [OP_W-1:0] OP_STORE    = 8'h10;
    localparam logic [OP_W-1:0] OP_LOAD_DIR = 8'h20;
    localparam logic [OP_W-1:0] OP_CALL     = 8'h30;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_ACK} phase_e;
    typedef enum logic [2:0] {SEL_IDLE, SEL_FREQ, SEL_FREL, SEL_XREQ, SEL_XREL} sel_state_e;

    function automatic int chain_stages(input int c);
        case (c)
            0:       return 2;
            1:       return 2;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [CHAIN_SEL_W-1:0] op_chain(input logic [OP_W-1:0] op);
        case (op)
            OP_ACC_NOT:  return CHAIN_SEL_W'(0);
            OP_LOAD_GPR: return CHAIN_SEL_W'(1);
            OP_STORE:    return CHAIN_SEL_W'(2);
            OP_LOAD_DIR: return CHAIN_SEL_W'(3);
            OP_CALL:     return CHAIN_SEL_W'(4);
            default:     return CHAIN_SEL_W'(0);
        endcase
    endfunction

    function automatic int fetch_code(input int idx);
        case (idx)
            0:       return STB_PC_MAR;
            1:       return STB_MAR_CLK;
            2:       return STB_RAM_CLK;
            3:       return STB_OPR_CLK;
            default: return NO_STB;
        endcase
    endfunction

    function automatic int exec_code(input logic [OP_W-1:0] op, input int idx);
        int r;
        r = NO_STB;
        case (op)
            OP_ACC_NOT: case (idx)
                0: r = STB_ACC_NOT;
                1: r = STB_ACC_CLK;
                default: r = NO_STB;
            endcase
            OP_LOAD_GPR: case (idx)
                0: r = STB_ALU_GPR;
                1: r = STB_ACC_CLK;
                default: r = NO_STB;
            endcase
            OP_STORE: case (idx)
                0: r = STB_GPR_MAR;
                1: r = STB_MAR_CLK;
                2: r = STB_ACC_GPR;
                3: r = STB_GPR_CLK;
                4: r = STB_RAM_WR;
                5: r = STB_RAM_CLK;
                default: r = NO_STB;
            endcase
            OP_LOAD_DIR: case (idx)
                0: r = STB_GPR_MAR;
                1: r = STB_MAR_CLK;
                2: r = STB_RAM_CLK;
                3: r = STB_MEM_GPR;
                4: r = STB_GPR_CLK;
                6: r = STB_ALU_GPR;
                7: r = STB_ACC_CLK;
                default: r = NO_STB;
            endcase
            OP_CALL: case (idx)
                0: r = STB_GPR_MAR;
                1: r = STB_MAR_CLK;
                2: r = STB_PC_GPR;
                3: r = STB_GPR_CLK;
                4: r = STB_MAR_PC;
                5: r = STB_PC_CLK;
                6: r = STB_RAM_WR;
                7: r = STB_RAM_CLK;
                8: r = STB_PC_INC;
                9: r = STB_PC_CLK;
                default: r = NO_STB;
            endcase
            default: r = NO_STB;
        endcase
        return r;
    endfunction

    function automatic logic [NUM_STB-1:0] code_to_strobe(input int code);
        logic [NUM_STB-1:0] one;
        one = NUM_STB'(1);
        if (code < 0) return '0;
        return one << code;
    endfunction
endpackage

// File: rtl/stepseq_chain.sv
module stepseq_chain
    import stepseq_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int IW     = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output logic          ack_o,
    output logic          active_o,
    output logic [IW-1:0] idx_o
);
    localparam logic [IW-1:0] LAST = IW'(STAGES - 1);

    typedef struct packed {
        phase_e        ph;
        logic [IW-1:0] idx;
    } chain_t;

    chain_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.ph)
            PH_IDLE: if (req_i) begin
                nxt_d.ph  = PH_RUN;
                nxt_d.idx = '0;
            end
            PH_RUN: begin
                if (cur_q.idx == LAST) nxt_d.ph = PH_ACK;
                else                   nxt_d.idx = cur_q.idx + IW'(1);
            end
            PH_ACK: if (!req_i) nxt_d.ph = PH_IDLE;
            default: nxt_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: PH_IDLE, idx: '0};
        else        cur_q <= nxt_d;
    end

    assign ack_o    = (cur_q.ph == PH_ACK);
    assign active_o = (cur_q.ph == PH_RUN);
    assign idx_o    = cur_q.idx;

    a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> req_i);
    a_r11_no_rerun_while_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> !active_o);
    a_r10_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (idx_o <= LAST));
endmodule

// File: rtl/stepseq_select.sv
module stepseq_select
    import stepseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [OP_W-1:0]       opcode_i,
    input  logic                  fetch_ack_i,
    input  logic [NUM_CHAINS-1:0] exec_ack_i,
    output logic                  fetch_req_o,
    output logic [NUM_CHAINS-1:0] exec_req_o,
    output logic [OP_W-1:0]       op_o,
    output logic                  fetch_start_o,
    output logic                  exec_start_o
);
    typedef struct packed {
        sel_state_e             st;
        logic [CHAIN_SEL_W-1:0] chain;
        logic [OP_W-1:0]        op;
        logic                   fstart;
        logic                   xstart;
    } sel_t;

    sel_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.fstart = 1'b0;
        nxt_d.xstart = 1'b0;
        case (cur_q.st)
            SEL_IDLE: if (start_i) begin
                nxt_d.st     = SEL_FREQ;
                nxt_d.fstart = 1'b1;
            end
            SEL_FREQ: if (fetch_ack_i) nxt_d.st = SEL_FREL;
            SEL_FREL: if (!fetch_ack_i) begin
                nxt_d.st     = SEL_XREQ;
                nxt_d.op     = opcode_i;
                nxt_d.chain  = op_chain(opcode_i);
                nxt_d.xstart = 1'b1;
            end
            SEL_XREQ: if (exec_ack_i[cur_q.chain]) nxt_d.st = SEL_XREL;
            SEL_XREL: if (!exec_ack_i[cur_q.chain]) begin
                nxt_d.st     = SEL_FREQ;
                nxt_d.fstart = 1'b1;
            end
            default: nxt_d.st = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: SEL_IDLE, chain: '0, op: '0, fstart: 1'b0, xstart: 1'b0};
        else        cur_q <= nxt_d;
    end

    always_comb begin
        for (int c = 0; c < NUM_CHAINS; c++)
            exec_req_o[c] = (cur_q.st == SEL_XREQ) && (cur_q.chain == CHAIN_SEL_W'(c));
    end

    assign fetch_req_o   = (cur_q.st == SEL_FREQ);
    assign op_o          = cur_q.op;
    assign fetch_start_o = cur_q.fstart;
    assign exec_start_o  = cur_q.xstart;

    a_r11_fetch_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_ack_i) |=> fetch_req_o);
    a_r11_exec_req_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|exec_req_o) |-> $past(|exec_ack_i));
    a_r11_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req_o, exec_req_o}));
endmodule

// File: rtl/stepseq_ctrl.sv
module stepseq_ctrl
    import stepseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [OP_W-1:0]    opcode_i,
    output logic [NUM_STB-1:0] strobe_o,
    output logic               fetch_start_o,
    output logic               exec_start_o
);
    logic                  fetch_req, fetch_ack, fetch_act;
    logic [IDX_W-1:0]      fetch_idx;
    logic [NUM_CHAINS-1:0] ex_req, ex_ack, ex_act;
    logic [IDX_W-1:0]      ex_idx [NUM_CHAINS];
    logic [OP_W-1:0]       sel_op;
    logic [IDX_W-1:0]      ex_sel_idx;
    int                    stb_code;

    stepseq_select u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .opcode_i     (opcode_i),
        .fetch_ack_i  (fetch_ack),
        .exec_ack_i   (ex_ack),
        .fetch_req_o  (fetch_req),
        .exec_req_o   (ex_req),
        .op_o         (sel_op),
        .fetch_start_o(fetch_start_o),
        .exec_start_o (exec_start_o)
    );

    stepseq_chain #(.STAGES(FETCH_STAGES), .IW(IDX_W)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (fetch_req),
        .ack_o   (fetch_ack),
        .active_o(fetch_act),
        .idx_o   (fetch_idx)
    );

    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_exec
        stepseq_chain #(.STAGES(chain_stages(g)), .IW(IDX_W)) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (ex_req[g]),
            .ack_o   (ex_ack[g]),
            .active_o(ex_act[g]),
            .idx_o   (ex_idx[g])
        );
    end

    always_comb begin
        ex_sel_idx = '0;
        for (int c = 0; c < NUM_CHAINS; c++)
            if (ex_act[c]) ex_sel_idx = ex_idx[c];
        if (fetch_act)    stb_code = fetch_code(int'(fetch_idx));
        else if (|ex_act) stb_code = exec_code(sel_op, int'(ex_sel_idx));
        else              stb_code = NO_STB;
        strobe_o = code_to_strobe(stb_code);
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));
    a_r3_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_start_o && exec_start_o));
    a_r11_one_chain_running: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_act, ex_act}));
endmodule

// File: tb/stepseq_ctrl_tb.sv
module stepseq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [7:0] V_OP  [NVEC] = '{8'h01, 8'h02, 8'h10, 8'h20, 8'h30, 8'hFF};
    localparam int         V_LEN [NVEC] = '{2, 2, 6, 8, 10, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] strobe;
    logic        fstart, xstart;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepseq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opcode),
        .strobe_o(strobe), .fetch_start_o(fstart), .exec_start_o(xstart)
    );

    function automatic int exp_fetch(input int k);
        case (k) 0: return 13; 1: return 3; 2: return 4; 3: return 14; default: return -1; endcase
    endfunction

    function automatic int exp_exec(input logic [7:0] op, input int k);
        int s10 [10];
        int s8 [8];
        int s6 [6];
        case (op)
            8'h01: return (k == 0) ? 0 : (k == 1) ? 1 : -1;
            8'h02: return (k == 0) ? 7 : (k == 1) ? 1 : -1;
            8'h10: begin s6 = '{2, 3, 15, 6, 11, 4}; return (k < 6) ? s6[k] : -1; end
            8'h20: begin s8 = '{2, 3, 4, 5, 6, -1, 7, 1}; return (k < 8) ? s8[k] : -1; end
            8'h30: begin s10 = '{2, 3, 8, 6, 9, 10, 11, 4, 12, 10}; return (k < 10) ? s10[k] : -1; end
            default: return -1;
        endcase
    endfunction

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'h01: return "R5"; 8'h02: return "R8"; 8'h10: return "R8";
            8'h20: return "R6"; 8'h30: return "R7"; default: return "R9";
        endcase
    endfunction

    function automatic logic [17:0] pack(input int code, input bit f, input bit x);
        logic [15:0] s;
        s = (code < 0) ? 16'h0 : (16'h1 << code);
        return {f, x, s};
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual fs/xs/strobe=%05h expected %05h at %0t", tag, act, exp, $time);
        end
    endtask

    // Entered in the cycle where fetch_start was observed; returns at the next one.
    task automatic do_instr(input logic [7:0] op, input int n, input bit start_mid);
        string tag;
        int    code;
        opcode = op;
        for (int c = 1; c <= 8 + n + 4; c++) begin
            @(posedge clk); #1;
            start = (start_mid && c == 2);
            code  = -1;
            tag   = op_tag(op);
            if (c <= 4) begin code = exp_fetch(c - 1); tag = "R2"; end
            else if (c > 8 && c <= 8 + n) code = exp_exec(op, c - 9);
            if (c == 8) tag = "R3";
            if (c == 8 + n + 4) tag = "R4";
            if (start_mid) tag = {tag, "/R13"};
            check(tag, {fstart, xstart, strobe}, pack(code, c == 8 + n + 4, c == 8));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: during and after reset, no activity without start
        repeat (3) @(posedge clk);
        #1 check("R1", {fstart, xstart, strobe}, 18'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check("R1", {fstart, xstart, strobe}, 18'h0);
        end
        // R2: start pulse, fetch marker next cycle
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check("R2", {fstart, xstart, strobe}, pack(-1, 1'b1, 1'b0));
        // vector table walk
        for (int v = 0; v < NVEC; v++) do_instr(V_OP[v], V_LEN[v], 1'b0);
        // R13: start during a running instruction
        do_instr(8'h20, 8, 1'b1);
        do_instr(8'h01, 2, 1'b0);
        // R12: reset in the middle of load-direct execution
        opcode = 8'h20;
        repeat (11) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1;
        check("R12", {fstart, xstart, strobe}, 18'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            check("R12", {fstart, xstart, strobe}, 18'h0);
        end
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check("R12", {fstart, xstart, strobe}, pack(-1, 1'b1, 1'b0));
        do_instr(8'h30, 10, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule